// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock

This peripheral keeps a 32-bit count of elapsed seconds for software. It sits on an APB-style register interface of 32-bit words and decodes a 4 KB window. The count advances once per second. A prescaler, set by a parameter, divides the bus clock to make that one-second step. Software can preset the count at any time. A preset also restarts the prescaler phase, so the first step after a preset comes exactly one full second later.

An alarm compare register raises a sticky status bit when the count steps onto the stored value. That bit is gated by a one-bit enable to drive a level interrupt output. Software clears the status bit by writing anything to a dedicated clear word. The run control word is fixed: it always reads as running and cannot stop the count. The top eight words of the window return a constant identification byte each, in bits 7:0.

Top module: `secs_rtc_top`

## Requirements
- R1: A write of V to word 0x08 sets the count to V on the write edge and restarts the prescaler. Word 0x00 reads V until TICKS_PER_SEC clocks after that edge, and reads V+1 from then on. Word 0x08 reads back the last value written to it.
- R2: Without a preset, the count at word 0x00 increases by exactly one every TICKS_PER_SEC clocks, and it wraps from 0xFFFFFFFF to 0.
- R3: Word 0x04 (alarm compare) reads back the full 32-bit value last written to it.
- R4: Word 0x10 (interrupt enable) keeps only bit 0 of the write data. Bits 31:1 read as zero.
- R5: When the count steps to a value equal to word 0x04, word 0x14 (raw status, bit 0) becomes 1 on that edge. Word 0x18 reads raw AND enable, and `irq_o` equals that same masked bit.
- R6: Any write to word 0x1C clears raw status. If a step onto the compare value falls on the same edge, the bit stays set. Word 0x1C reads as zero.
- R7: Word 0x0C reads 1. A write to it has no effect on the count and is not an error.
- R8: Words 0xFE0..0xFFC return, in bits 7:0 with the upper bits zero, the bytes 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1, in ascending address order. A write there sets `pslverr` and has no effect.
- R9: Reads of 0x020..0xFDC return zero. A write to that range, or to words 0x00, 0x14 or 0x18, sets `pslverr` and changes no state.
- R10: After reset, the count, compare, preset, enable and raw status are all zero and `irq_o` is low. `pready` is always 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, also drives the prescaler |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address within the 4 KB window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Always 1, no wait states |
| pslverr | output | 1 | Error on writes to read-only or unused words |
| irq_o | output | 1 | Level interrupt, raw status AND enable |

## Verification
Read data and `pslverr` are combinational in the access phase, so the bench samples them shortly after the falling edge inside that phase. A register write takes effect on the rising edge that ends its access phase. After a preset lands on edge E, the count changes on edge E+TICKS_PER_SEC. Raw status and `irq_o` change on that same edge. Every check counts falling edges from the preset so that its read samples on a known side of that step. The same-edge case of R6 places the clear's write edge exactly on E+TICKS_PER_SEC.

// File: rtl/secs_rtc_pkg.sv
package secs_rtc_pkg;
    localparam int DW  = 32;
    localparam int AW  = 12;
    localparam int WIW = AW - 2;

    localparam logic [WIW-1:0] W_SECS    = 10'h000;
    localparam logic [WIW-1:0] W_MATCH   = 10'h001;
    localparam logic [WIW-1:0] W_LOAD    = 10'h002;
    localparam logic [WIW-1:0] W_CTRL    = 10'h003;
    localparam logic [WIW-1:0] W_ENA     = 10'h004;
    localparam logic [WIW-1:0] W_RAW     = 10'h005;
    localparam logic [WIW-1:0] W_MSKD    = 10'h006;
    localparam logic [WIW-1:0] W_CLR     = 10'h007;
    localparam logic [WIW-1:0] W_ID_BASE = 10'h3F8;

    typedef struct packed {
        logic           rd;
        logic           wr;
        logic [WIW-1:0] widx;
        logic [DW-1:0]  wdata;
    } bus_req_t;

    function automatic logic [7:0] id_byte(input logic [2:0] i);
        case (i)
            3'd0:    return 8'h31;
            3'd1:    return 8'h10;
            3'd2:    return 8'h14;
            3'd3:    return 8'h00;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction

    function automatic logic in_id(input logic [WIW-1:0] w);
        return w >= W_ID_BASE;
    endfunction

    function automatic logic wr_allowed(input logic [WIW-1:0] w);
        return (w == W_MATCH) || (w == W_LOAD) || (w == W_CTRL) ||
               (w == W_ENA) || (w == W_CLR);
    endfunction
endpackage

// File: rtl/secs_rtc_prescale.sv
module secs_rtc_prescale #(
    parameter int TICKS_PER_SEC = 125_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == LAST) && !restart;

    always_ff @(posedge clk) begin
        if (rst || restart || cnt_q == LAST) cnt_q <= '0;
        else                                 cnt_q <= cnt_q + 1'b1;
    end

    a_r1_phase_reset: assert property (@(posedge clk) disable iff (rst)
        restart |=> cnt_q == '0);

    generate
        if (TICKS_PER_SEC > 1) begin : g_spacing
            a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/secs_rtc_counter.sv
module secs_rtc_counter
    import secs_rtc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          load_en,
    input  logic [DW-1:0] load_val,
    input  logic [DW-1:0] match_val,
    output logic [DW-1:0] secs_o,
    output logic          hit_o
);
    logic [DW-1:0] secs_q;
    logic [DW-1:0] secs_nxt;

    assign secs_nxt = secs_q + DW'(1);
    assign secs_o   = secs_q;
    assign hit_o    = tick && !load_en && (secs_nxt == match_val);

    always_ff @(posedge clk) begin
        if (rst)          secs_q <= '0;
        else if (load_en) secs_q <= load_val;
        else if (tick)    secs_q <= secs_nxt;
    end

    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (tick && !load_en) |=> secs_q == $past(secs_q) + DW'(1));
    a_r1_load: assert property (@(posedge clk) disable iff (rst)
        load_en |=> secs_q == $past(load_val));
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load_en) |=> $stable(secs_q));
endmodule

// File: rtl/secs_rtc_regs.sv
module secs_rtc_regs
    import secs_rtc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  bus_req_t      req,
    input  logic [DW-1:0] secs_i,
    input  logic          hit_i,
    output logic [DW-1:0] rdata_o,
    output logic          err_o,
    output logic          load_en_o,
    output logic [DW-1:0] load_val_o,
    output logic [DW-1:0] match_o,
    output logic          irq_o
);
    logic [DW-1:0] match_q;
    logic [DW-1:0] load_q;
    logic          ena_q;
    logic          raw_q;
    logic          clr_wr;

    assign clr_wr     = req.wr && (req.widx == W_CLR);
    assign load_en_o  = req.wr && (req.widx == W_LOAD);
    assign load_val_o = req.wdata;
    assign match_o    = match_q;
    assign err_o      = req.wr && !wr_allowed(req.widx);
    assign irq_o      = raw_q & ena_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            match_q <= '0;
            load_q  <= '0;
            ena_q   <= 1'b0;
            raw_q   <= 1'b0;
        end else begin
            if (req.wr && req.widx == W_MATCH) match_q <= req.wdata;
            if (load_en_o)                     load_q  <= req.wdata;
            if (req.wr && req.widx == W_ENA)   ena_q   <= req.wdata[0];
            if (hit_i)       raw_q <= 1'b1;
            else if (clr_wr) raw_q <= 1'b0;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (req.rd) begin
            if (in_id(req.widx)) begin
                rdata_o = {{(DW-8){1'b0}}, id_byte(req.widx[2:0])};
            end else begin
                case (req.widx)
                    W_SECS:  rdata_o = secs_i;
                    W_MATCH: rdata_o = match_q;
                    W_LOAD:  rdata_o = load_q;
                    W_CTRL:  rdata_o = DW'(1);
                    W_ENA:   rdata_o = {{(DW-1){1'b0}}, ena_q};
                    W_RAW:   rdata_o = {{(DW-1){1'b0}}, raw_q};
                    W_MSKD:  rdata_o = {{(DW-1){1'b0}}, raw_q & ena_q};
                    default: rdata_o = '0;
                endcase
            end
        end
    end

    a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
        hit_i |=> raw_q);
    a_r6_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && !hit_i) |=> !raw_q);
    a_r5_raw_source: assert property (@(posedge clk) disable iff (rst)
        $rose(raw_q) |-> $past(hit_i));
    a_r4_ena_high_zero: assert property (@(posedge clk) disable iff (rst)
        (req.rd && req.widx == W_ENA) |-> rdata_o[DW-1:1] == '0);
    a_r7_ctrl_one: assert property (@(posedge clk) disable iff (rst)
        (req.rd && req.widx == W_CTRL) |-> rdata_o == DW'(1));
    a_r8_id_write_err: assert property (@(posedge clk) disable iff (rst)
        (req.wr && in_id(req.widx)) |-> err_o);
    a_r9_err_no_effect: assert property (@(posedge clk) disable iff (rst)
        err_o |=> $stable(match_q) && $stable(load_q) && $stable(ena_q));
endmodule

// File: rtl/secs_rtc_top.sv
module secs_rtc_top
    import secs_rtc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 125_000_000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic [AW-1:0] paddr,
    input  logic [DW-1:0] pwdata,
    output logic [DW-1:0] prdata,
    output logic          pready,
    output logic          pslverr,
    output logic          irq_o
);
    bus_req_t      req;
    logic          tick;
    logic          load_en;
    logic [DW-1:0] load_val;
    logic [DW-1:0] match_val;
    logic [DW-1:0] secs;
    logic          hit;

    always_comb begin
        req.rd    = psel && penable && !pwrite;
        req.wr    = psel && penable && pwrite;
        req.widx  = paddr[AW-1:2];
        req.wdata = pwdata;
    end

    assign pready = 1'b1;

    secs_rtc_prescale #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
        .clk(clk), .rst(rst), .restart(load_en), .tick(tick)
    );

    secs_rtc_counter u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .load_en(load_en),
        .load_val(load_val), .match_val(match_val),
        .secs_o(secs), .hit_o(hit)
    );

    secs_rtc_regs u_regs (
        .clk(clk), .rst(rst), .req(req), .secs_i(secs), .hit_i(hit),
        .rdata_o(prdata), .err_o(pslverr), .load_en_o(load_en),
        .load_val_o(load_val), .match_o(match_val), .irq_o(irq_o)
    );

    a_r10_irq_reset: assert property (@(posedge clk)
        rst |=> !irq_o);
endmodule

// File: tb/secs_rtc_top_tb_top.sv
module secs_rtc_top_tb_top;
    localparam int TPS = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic        pslverr;
    logic        irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    secs_rtc_top #(.TICKS_PER_SEC(TPS)) dut_i (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .irq_o(irq_o)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", rq, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Called just after a falling edge; the write lands two rising edges later.
    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d, output logic err);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1 err = pslverr;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d, output logic err);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1 begin d = prdata; err = pslverr; end
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d; logic e;
        bus_rd(12'h000, d, e); chk("R10 count", d, 0);
        bus_rd(12'h004, d, e); chk("R10 compare", d, 0);
        bus_rd(12'h008, d, e); chk("R10 preset", d, 0);
        bus_rd(12'h010, d, e); chk("R10 enable", d, 0);
        bus_rd(12'h014, d, e); chk("R10 raw", d, 0);
        #1 chk("R10 irq", {31'b0, irq_o}, 0);
        chk("R10 pready", {31'b0, pready}, 1);
    endtask

    task automatic t_preset_timing;
        logic [31:0] d; logic e;
        bus_wr(12'h008, 32'h0000_1234, e);
        chk("R1 preset no err", {31'b0, e}, 0);
        wait_neg(TPS - 2);
        bus_rd(12'h000, d, e); chk("R1 before step", d, 32'h1234);
        bus_rd(12'h000, d, e); chk("R1 after step", d, 32'h1235);
        bus_rd(12'h008, d, e); chk("R1 preset readback", d, 32'h1234);
        wait_neg(TPS - 2);
        bus_rd(12'h000, d, e); chk("R2 second step", d, 32'h1236);
    endtask

    task automatic t_wrap;
        logic [31:0] d; logic e;
        bus_wr(12'h008, 32'hFFFF_FFFF, e);
        wait_neg(TPS - 2);
        bus_rd(12'h000, d, e); chk("R2 before wrap", d, 32'hFFFF_FFFF);
        bus_rd(12'h000, d, e); chk("R2 wrap to zero", d, 0);
    endtask

    task automatic t_compare_rw;
        logic [31:0] d; logic e;
        bus_wr(12'h004, 32'hA5C3_0F96, e);
        bus_rd(12'h004, d, e); chk("R3 compare readback", d, 32'hA5C3_0F96);
    endtask

    task automatic t_enable;
        logic [31:0] d; logic e;
        bus_wr(12'h010, 32'hFFFF_FFFF, e);
        bus_rd(12'h010, d, e); chk("R4 enable bit0 only", d, 1);
        bus_wr(12'h010, 32'hFFFF_FFFE, e);
        bus_rd(12'h010, d, e); chk("R4 enable cleared", d, 0);
    endtask

    task automatic t_alarm;
        logic [31:0] d; logic e;
        bus_wr(12'h01C, 0, e);
        bus_wr(12'h004, 32'h0000_1001, e);
        bus_wr(12'h008, 32'h0000_1000, e);
        wait_neg(TPS - 2);
        bus_rd(12'h014, d, e); chk("R5 raw before match", d, 0);
        bus_rd(12'h014, d, e); chk("R5 raw after match", d, 1);
        bus_rd(12'h018, d, e); chk("R5 masked with enable 0", d, 0);
        #1 chk("R5 irq with enable 0", {31'b0, irq_o}, 0);
        bus_wr(12'h010, 1, e);
        bus_rd(12'h018, d, e); chk("R5 masked with enable 1", d, 1);
        #1 chk("R5 irq with enable 1", {31'b0, irq_o}, 1);
        bus_wr(12'h01C, 32'h0, e);
        bus_rd(12'h014, d, e); chk("R6 raw cleared", d, 0);
        #1 chk("R6 irq dropped", {31'b0, irq_o}, 0);
        bus_rd(12'h01C, d, e); chk("R6 clear word reads zero", d, 0);
        bus_wr(12'h010, 0, e);
    endtask

    task automatic t_set_wins;
        logic [31:0] d; logic e;
        bus_wr(12'h004, 32'h0000_2001, e);
        bus_wr(12'h008, 32'h0000_2000, e);
        wait_neg(TPS - 2);
        bus_wr(12'h01C, 32'hDEAD_BEEF, e);   // lands on the step edge
        bus_rd(12'h014, d, e); chk("R6 set wins over clear", d, 1);
        bus_wr(12'h01C, 0, e);
        bus_rd(12'h014, d, e); chk("R6 later clear", d, 0);
    endtask

    task automatic t_control;
        logic [31:0] d; logic e;
        bus_rd(12'h00C, d, e); chk("R7 control reads 1", d, 1);
        bus_wr(12'h008, 32'h0000_0500, e);
        bus_wr(12'h00C, 0, e);
        chk("R7 control write no err", {31'b0, e}, 0);
        bus_rd(12'h00C, d, e); chk("R7 control still 1", d, 1);
        wait_neg(TPS - 4);
        bus_rd(12'h000, d, e); chk("R7 count still runs", d, 32'h0000_0501);
    endtask

    task automatic t_ident;
        logic [31:0] d; logic e;
        logic [7:0] exp_b [8] = '{8'h31, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        for (int i = 0; i < 8; i++) begin
            bus_rd(12'hFE0 + 12'(4 * i), d, e);
            chk("R8 ident byte", d, {24'b0, exp_b[i]});
        end
        bus_wr(12'hFE0, 32'h0000_0077, e);
        chk("R8 ident write err", {31'b0, e}, 1);
        bus_rd(12'hFE0, d, e); chk("R8 ident unchanged", d, 32'h31);
    endtask

    task automatic t_reserved;
        logic [31:0] d; logic e;
        bus_rd(12'h100, d, e); chk("R9 reserved read", d, 0);
        bus_rd(12'hFDC, d, e); chk("R9 reserved top read", d, 0);
        bus_wr(12'h020, 32'h1, e); chk("R9 reserved write err", {31'b0, e}, 1);
        bus_wr(12'h004, 32'h0000_0042, e);
        bus_wr(12'h008, 32'h0000_0100, e);
        bus_wr(12'h000, 32'h0000_0055, e);
        chk("R9 count write err", {31'b0, e}, 1);
        bus_rd(12'h000, d, e); chk("R9 count unchanged", d, 32'h100);
        bus_wr(12'h014, 32'h1, e); chk("R9 raw write err", {31'b0, e}, 1);
        bus_rd(12'h014, d, e); chk("R9 raw unchanged", d, 0);
        bus_wr(12'h018, 32'h1, e); chk("R9 masked write err", {31'b0, e}, 1);
        bus_rd(12'h004, d, e); chk("R9 compare unchanged", d, 32'h42);
    endtask

    initial begin
        wait_neg(4);
        rst = 1'b0;
        t_reset();
        t_preset_timing();
        t_wrap();
        t_compare_rw();
        t_enable();
        t_alarm();
        t_set_wins();
        t_control();
        t_ident();
        t_reserved();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog all requirements actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule